// File: doc/BRIEF.md
# Pseudo-SRAM Asynchronous Read Controller

This block sits between a synchronous host and a 16-bit pseudo-static RAM and turns each host read request into an asynchronous read waveform on the memory pins: chip select, output enable, the lower and upper byte strobes and the address. All analogue timing limits of the memory are given as times in picoseconds. They are converted at elaboration into whole clock cycles, always rounded up, and every wait inside the controller is a cycle count.

A host read is a level request carrying an address, two byte-lane enables and a burst flag. The request is held until a single-cycle acknowledge comes back together with the captured word. Lanes that were not enabled read as zero. When a burst read asks for the address already open, the controller keeps chip select low and only pulses output enable and the byte strobes again. This gives shorter same-address reads. The memory also limits how long chip select may stay low in total. The controller therefore tracks the accumulated low time. It breaks the chip-select-low period before that limit is reached, both when a further burst read would not fit and when the host leaves the row idle.

The address only changes while chip select is high, and it changes on the same edge at which chip select falls. The skew window after chip select falls is therefore met with no added delay.

Top module: `psram_rd_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, chip select, output enable and both byte strobes are high (inactive), and ack is low.
- R2: A new read cycle starts on one clock edge that lowers chip select, drives the request address and lowers output enable together with the strobes of the enabled lanes. Lane 0 (req_be bit 0) maps to mem_lb_n and data bits 7:0. Lane 1 (req_be bit 1) maps to mem_ub_n and data bits 15:8. The address does not change while chip select is low, and a byte strobe is never low while output enable is high.
- R3: In a read that opens a new chip-select-low period, data is captured on the edge FIRST_DONE+1 cycles after chip select falls, where FIRST_DONE = max(address access, output-enable access, read cycle − 1) in cycles. From idle, ack is first seen FIRST_DONE+2 cycles after the request appears (12 cycles for the 125 MHz default timing).
- R4: rdata carries the captured lane when that lane was enabled and zero when it was not.
- R5: A request with req_burst=1 and the open address, accepted while chip select is low, keeps chip select low. It reasserts output enable and the strobes and captures after TOG_DONE+1 cycles, where TOG_DONE = max(output-enable access, read cycle − 1). Issued in the ack cycle of the previous read, its ack comes 15 cycles later at default timing.
- R6: Output enable stays high for at least HZ_CYC+1 cycles (the bus float time rounded up, plus one) before it is lowered again.
- R7: A request that is not a same-address burst raises chip select while a row is open. Chip select then stays high for at least the minimum pulse width before a full new cycle starts. Issued in an ack cycle, its ack comes 16 cycles later at default timing.
- R8: Chip select is never low for more than MAX_CYC consecutive cycles. A burst read that would cross this limit instead raises chip select and restarts with a full cycle (16 cycles at default timing).
- R9: With no request, an open row is closed on the first edge at which the low time already counted, plus TOG_DONE+3, exceeds MAX_CYC.
- R10: ack is high for exactly one cycle per read. A request present in the ack cycle is not accepted until the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held until ack |
| req_addr | input | AW | Word address of the read |
| req_be | input | 2 | Lane enables: bit 0 low byte, bit 1 high byte |
| req_burst | input | 1 | Allow a same-address read without closing the row |
| ack | output | 1 | One-cycle read completion |
| rdata | output | 16 | Captured word, unselected lanes zero, valid with ack |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq | input | 16 | Memory data bus |

## Verification
The bound checker watches the pin-level rules on every cycle: the low-time ceiling on chip select, the address holding still during a low period, the strobes nested under output enable, the float gap before output enable returns, the chip-select high pulse, and the single-cycle ack with zeroed lanes. Only the bench scenarios can show that data is captured late enough in each kind of read, that a burst keeps the row open, and that a mismatched or over-long burst closes it. The same holds for the exact latencies and for the idle row being released at the computed point, because these depend on the request sequence and on a memory model whose data becomes valid only after the access times.

// File: rtl/psram_rd_pkg.sv
`timescale 1ns/1ps
package psram_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_OPEN = 2'd2,
        ST_GAP  = 2'd3
    } prd_state_e;

    // Whole clock cycles covering a time, rounded up.
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prd_lowtime_meter.sv
`timescale 1ns/1ps
// Counts consecutive chip-select-low cycles and tells whether another
// same-address read still fits under the ceiling.
module prd_lowtime_meter #(
    parameter int MAX_CYC  = 1250,
    parameter int TOG_DONE = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low_d,
    output logic fit_now,
    output logic fit_later
);
    localparam int RW = $clog2(MAX_CYC + 2);
    localparam logic [RW-1:0] RUN_TOP = RW'(MAX_CYC + 1);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = '0;
        if (cs_low_d) begin
            run_d = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
        end
        fit_now   = (32'(run_q) + 32'(TOG_DONE) + 32'd2) <= 32'(MAX_CYC);
        fit_later = (32'(run_q) + 32'(TOG_DONE) + 32'd3) <= 32'(MAX_CYC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/prd_float_timer.sv
`timescale 1ns/1ps
// Tracks cycles since the data-bus drivers of the memory were switched off.
module prd_float_timer #(
    parameter int HZ_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_q,
    input  logic drive_d,
    output logic float_done
);
    localparam int FW = $clog2(HZ_CYC + 2);
    localparam logic [FW-1:0] FLOAT_TOP = FW'(HZ_CYC);

    logic [FW-1:0] flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (drive_q && !drive_d) begin
            flt_d = '0;
        end else if (!drive_q && (flt_q < FLOAT_TOP)) begin
            flt_d = flt_q + 1'b1;
        end
        float_done = (flt_q >= FLOAT_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= FLOAT_TOP;
        end else begin
            flt_q <= flt_d;
        end
    end

endmodule

// File: rtl/prd_lane_capture.sv
`timescale 1ns/1ps
// Captures the memory word lane by lane and raises a one-cycle ack.
module prd_lane_capture #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] dq,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    ack
);
    logic [LANES*LANE_W-1:0] data_d, data_q;
    logic                    ack_d, ack_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            data_d[g*LANE_W +: LANE_W] = data_q[g*LANE_W +: LANE_W];
            if (capture) begin
                data_d[g*LANE_W +: LANE_W] = lane_en[g] ? dq[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_comb begin
        ack_d = capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            ack_q  <= ack_d;
        end
    end

    assign rdata = data_q;
    assign ack   = ack_q;

endmodule

// File: rtl/psram_rd_ctrl.sv
`timescale 1ns/1ps
module psram_rd_ctrl
    import psram_rd_pkg::*;
#(
    parameter int AW        = 22,
    parameter int CLK_PS    = 8000,
    parameter int T_RC_PS   = 80000,
    parameter int T_AA_PS   = 80000,
    parameter int T_OE_PS   = 35000,
    parameter int T_CP_PS   = 10000,
    parameter int T_HZ_PS   = 25000,
    parameter int T_MAX_PS  = 10000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_be,
    input  logic          req_burst,
    output logic          ack,
    output logic [15:0]   rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    input  logic [15:0]   mem_dq
);
    localparam int LANES      = 2;
    localparam int LANE_W     = 8;
    localparam int RC_CYC     = cyc_of(T_RC_PS, CLK_PS);
    localparam int AA_CYC     = cyc_of(T_AA_PS, CLK_PS);
    localparam int OE_CYC     = cyc_of(T_OE_PS, CLK_PS);
    localparam int CP_CYC     = max_of(1, cyc_of(T_CP_PS, CLK_PS));
    localparam int HZ_CYC     = cyc_of(T_HZ_PS, CLK_PS);
    localparam int MAX_CYC    = T_MAX_PS / CLK_PS;
    localparam int FIRST_DONE = max_of(max_of(AA_CYC, OE_CYC), RC_CYC - 1);
    localparam int TOG_DONE   = max_of(OE_CYC, RC_CYC - 1);
    localparam int CW         = $clog2(FIRST_DONE + CP_CYC + 2);

    typedef struct packed {
        prd_state_e       state;
        logic [CW-1:0]    cnt;
        logic             first;
        logic [AW-1:0]    addr;
        logic             cs_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic capture_d;
    logic hz_ok, fit_now, fit_later, ack_q;
    logic take, same_row;

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        nxt_d     = cur_q;
        capture_d = 1'b0;
        take      = req && !ack_q;
        same_row  = req_burst && (req_addr == cur_q.addr);

        unique case (cur_q.state)
            ST_IDLE: begin
                if (take && hz_ok) begin
                    nxt_d.state  = ST_READ;
                    nxt_d.cs_n   = 1'b0;
                    nxt_d.oe_n   = 1'b0;
                    nxt_d.lane_n = ~req_be;
                    nxt_d.addr   = req_addr;
                    nxt_d.first  = 1'b1;
                    nxt_d.cnt    = '0;
                end
            end

            ST_READ: begin
                if (cur_q.cnt == (cur_q.first ? CW'(FIRST_DONE) : CW'(TOG_DONE))) begin
                    capture_d    = 1'b1;
                    nxt_d.oe_n   = 1'b1;
                    nxt_d.lane_n = '1;
                    nxt_d.state  = ST_OPEN;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end

            ST_OPEN: begin
                if (take && same_row && hz_ok && fit_now) begin
                    nxt_d.state  = ST_READ;
                    nxt_d.oe_n   = 1'b0;
                    nxt_d.lane_n = ~req_be;
                    nxt_d.first  = 1'b0;
                    nxt_d.cnt    = '0;
                end else if ((take && !same_row) || !fit_later) begin
                    nxt_d.state = ST_GAP;
                    nxt_d.cs_n  = 1'b1;
                    nxt_d.cnt   = '0;
                end
            end

            ST_GAP: begin
                if (cur_q.cnt >= CW'(CP_CYC - 1)) begin
                    nxt_d.state = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end

            default: nxt_d.state = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state  <= ST_IDLE;
            cur_q.cnt    <= '0;
            cur_q.first  <= 1'b0;
            cur_q.addr   <= '0;
            cur_q.cs_n   <= 1'b1;
            cur_q.oe_n   <= 1'b1;
            cur_q.lane_n <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // ---------------------------------------------------------------
    // Helpers
    // ---------------------------------------------------------------
    prd_lowtime_meter #(
        .MAX_CYC  (MAX_CYC),
        .TOG_DONE (TOG_DONE)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low_d  (!nxt_d.cs_n),
        .fit_now   (fit_now),
        .fit_later (fit_later)
    );

    prd_float_timer #(
        .HZ_CYC (HZ_CYC)
    ) u_float (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_q    (!cur_q.oe_n),
        .drive_d    (!nxt_d.oe_n),
        .float_done (hz_ok)
    );

    prd_lane_capture #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture_d),
        .lane_en (~cur_q.lane_n),
        .dq      (mem_dq),
        .rdata   (rdata),
        .ack     (ack_q)
    );

    assign ack      = ack_q;
    assign mem_addr = cur_q.addr;
    assign mem_cs_n = cur_q.cs_n;
    assign mem_oe_n = cur_q.oe_n;
    assign mem_lb_n = cur_q.lane_n[0];
    assign mem_ub_n = cur_q.lane_n[1];

endmodule

// File: rtl/prd_checker.sv
`timescale 1ns/1ps
module prd_checker #(
    parameter int AW      = 22,
    parameter int MAX_CYC = 1250,
    parameter int HZ_CYC  = 4,
    parameter int CP_CYC  = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic [15:0]   rdata,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_lb_n,
    input logic          mem_ub_n
);
    localparam int RW = $clog2(MAX_CYC + 3);
    localparam int OW = $clog2(HZ_CYC + 3);
    localparam int HW = $clog2(CP_CYC + 2);

    logic [RW-1:0] low_run_q;
    logic [OW-1:0] oe_off_q;
    logic [HW-1:0] cs_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            oe_off_q  <= OW'(HZ_CYC + 1);
            cs_hi_q   <= HW'(CP_CYC);
        end else begin
            if (mem_cs_n) begin
                low_run_q <= '0;
            end else if (low_run_q != RW'(MAX_CYC + 2)) begin
                low_run_q <= low_run_q + 1'b1;
            end
            if (!mem_oe_n) begin
                oe_off_q <= '0;
            end else if (oe_off_q != OW'(HZ_CYC + 1)) begin
                oe_off_q <= oe_off_q + 1'b1;
            end
            if (!mem_cs_n) begin
                cs_hi_q <= '0;
            end else if (cs_hi_q != HW'(CP_CYC)) begin
                cs_hi_q <= cs_hi_q + 1'b1;
            end
        end
    end

    assert_cs_run_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(low_run_q) <= 32'(MAX_CYC));

    assert_oe_under_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);

    assert_strobe_under_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_lb_n || !mem_ub_n) |-> !mem_oe_n);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

    assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (32'(oe_off_q) >= 32'(HZ_CYC + 1)));

    assert_cs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (32'(cs_hi_q) >= 32'(CP_CYC)));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_low_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(mem_lb_n)) |-> (rdata[7:0] == 8'h00));

    assert_high_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(mem_ub_n)) |-> (rdata[15:8] == 8'h00));

endmodule

bind psram_rd_ctrl prd_checker #(
    .AW      (AW),
    .MAX_CYC (MAX_CYC),
    .HZ_CYC  (HZ_CYC),
    .CP_CYC  (CP_CYC)
) u_prd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .rdata    (rdata),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n)
);

// File: tb/psram_rd_ctrl_bench.sv
`timescale 1ns/1ps
module psram_rd_ctrl_bench;
    localparam int AW = 22;
    // Bench timing at 8 ns clock: access 10, output enable 5, cycle 10,
    // float 4, min pulse 2 cycles; low-time ceiling 50 cycles.
    localparam int HZ_CYC  = 4;
    localparam int CP_CYC  = 2;
    localparam int MAX_CYC = 50;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic          burst;
        logic [7:0]    lat;
        logic          brk;
    } vec_t;

    localparam logic [AW-1:0] A0 = 22'h01234;
    localparam logic [AW-1:0] A1 = 22'h2ABCD;

    // Latencies: from idle 12 (R3), burst 15 (R5), close-and-reopen 16 (R7, R8).
    localparam vec_t VECS [9] = '{
        '{A0, 2'b11, 1'b0, 8'd12, 1'b0},
        '{A0, 2'b01, 1'b1, 8'd15, 1'b0},
        '{A0, 2'b10, 1'b1, 8'd15, 1'b0},
        '{A0, 2'b11, 1'b1, 8'd16, 1'b1},
        '{A1, 2'b11, 1'b1, 8'd16, 1'b1},
        '{A1, 2'b11, 1'b0, 8'd16, 1'b1},
        '{A1, 2'b10, 1'b1, 8'd15, 1'b0},
        '{A1, 2'b01, 1'b1, 8'd15, 1'b0},
        '{A1, 2'b11, 1'b1, 8'd16, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = 2'b00;
    logic          req_burst = 1'b0;
    logic          ack;
    logic [15:0]   rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0]   mem_dq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cs_lo_cnt = 0;
    int oe_lo_cnt = 0;
    int run = 0;
    int last_run = 0;
    int max_run = 0;
    int oe_hi = 100;
    int cs_hi = 100;
    int min_oe_gap = 1000;
    int min_cs_gap = 1000;
    logic prev_oe_n = 1'b1;
    logic prev_cs_n = 1'b1;

    always #4 clk = ~clk;

    psram_rd_ctrl #(
        .AW       (AW),
        .T_MAX_PS (400000)
    ) u_psram_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_burst (req_burst),
        .ack       (ack),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_lb_n  (mem_lb_n),
        .mem_ub_n  (mem_ub_n),
        .mem_dq    (mem_dq)
    );

    function automatic logic [15:0] pattern(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Memory model: data valid only 80 ns after chip select and 35 ns after output enable.
    always_comb begin
        mem_dq = ((cs_lo_cnt >= 10) && (oe_lo_cnt >= 5)) ? pattern(mem_addr) : 16'h0BAD;
    end

    always @(negedge clk) begin
        cyc++;
        cs_lo_cnt = mem_cs_n ? 0 : cs_lo_cnt + 1;
        oe_lo_cnt = mem_oe_n ? 0 : oe_lo_cnt + 1;
        if (rst_n) begin
            if (!mem_cs_n) begin
                run++;
                if (run > max_run) max_run = run;
                if (prev_cs_n && cs_hi < min_cs_gap) min_cs_gap = cs_hi;
                cs_hi = 0;
            end else begin
                if (run != 0) last_run = run;
                run = 0;
                cs_hi++;
            end
            if (!mem_oe_n) begin
                if (prev_oe_n && oe_hi < min_oe_gap) min_oe_gap = oe_hi;
                oe_hi = 0;
            end else begin
                oe_hi++;
            end
        end
        prev_cs_n = mem_cs_n;
        prev_oe_n = mem_oe_n;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle_pins(input string tag);
        chk(mem_cs_n == 1'b1, {tag, " cs_n"}, 32'(mem_cs_n), 32'd1);
        chk(mem_oe_n == 1'b1, {tag, " oe_n"}, 32'(mem_oe_n), 32'd1);
        chk(mem_lb_n == 1'b1, {tag, " lb_n"}, 32'(mem_lb_n), 32'd1);
        chk(mem_ub_n == 1'b1, {tag, " ub_n"}, 32'(mem_ub_n), 32'd1);
        chk(ack == 1'b0, {tag, " ack"}, 32'(ack), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle_pins("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_pins("R1 after reset");

        // Vector walk: each request is presented in the ack cycle of the previous one.
        for (int i = 0; i < 9; i++) begin
            logic [15:0] exp_data;
            int   lat;
            bit   brk;
            logic saw_lb, saw_ub;
            vec_t v;
            v = VECS[i];
            req = 1'b1; req_addr = v.addr; req_be = v.be; req_burst = v.burst;
            lat = 0; brk = 1'b0; saw_lb = 1'b1; saw_ub = 1'b1;
            do begin
                @(negedge clk);
                lat++;
                if (lat == 1) chk(ack == 1'b0, "R10 ack single cycle", 32'(ack), 32'd0);
                if (mem_cs_n) brk = 1'b1;
                if (!mem_oe_n) begin saw_lb = mem_lb_n; saw_ub = mem_ub_n; end
            end while (!ack && lat < 200);
            exp_data = pattern(v.addr) & {{8{v.be[1]}}, {8{v.be[0]}}};
            chk(lat == int'(v.lat), (v.burst && !v.brk) ? "R5 burst latency" :
                (i == 0 ? "R3 first latency" : "R7/R8 reopen latency (R7 R8)"),
                32'(lat), 32'(v.lat));
            chk(rdata == exp_data, "R4 lane data", 32'(rdata), 32'(exp_data));
            chk(brk == v.brk, v.brk ? "R8 row closed" : "R5 row kept open",
                32'(brk), 32'(v.brk));
            chk({saw_ub, saw_lb} == ~v.be, "R2 lane strobes", 32'({saw_ub, saw_lb}), 32'(~v.be));
        end

        // Idle release: no further request after the last ack.
        req = 1'b0;
        for (int k = 0; k < 100 && !mem_cs_n; k++) @(negedge clk);
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R9 idle row released", 32'(mem_cs_n), 32'd1);
        chk(last_run == 39, "R9 idle low run length", 32'(last_run), 32'd39);
        chk(max_run <= MAX_CYC, "R8 longest low run", 32'(max_run), 32'(MAX_CYC));
        chk(min_oe_gap >= HZ_CYC + 1, "R6 output enable float gap", 32'(min_oe_gap), 32'(HZ_CYC + 1));
        chk(min_cs_gap >= CP_CYC, "R7 chip select high pulse", 32'(min_cs_gap), 32'(CP_CYC));

        // Reset in the middle of a read.
        req = 1'b1; req_addr = A1; req_be = 2'b11; req_burst = 1'b0;
        repeat (5) @(negedge clk);
        chk(mem_cs_n == 1'b0, "R2 read started", 32'(mem_cs_n), 32'd0);
        rst_n = 1'b0;
        req = 1'b0;
        @(negedge clk);
        check_idle_pins("R1 reset mid read");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_pins("R1 released after mid read");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule